// File: doc/BRIEF.md
# Parity-in-LSB Protected Parameter Memory

This block stores fixed-width neural-network parameters in a single-port synchronous array without widening the word. On every write the lowest bit of the incoming parameter is dropped and replaced by an even-parity bit computed over the upper bits. A clean stored word therefore XORs to zero across all of its bits.

On a read the stored word is checked one cycle later. If the parity holds, the upper bits are returned with the lowest bit cleared. If the parity fails, the parameter is replaced by zero, an error flag is raised alongside the read strobe, and a saturating detection counter advances. Most parameters sit near zero, so a zeroed word costs little accuracy.

A test-only injection port XORs a chosen mask into any stored word. It lets a bench flip selected bits and observe masking or escape.

Top module: `lsbp_weight_mem`

## Requirements
- R1: A stored word is W bits wide (default 16) with no extra protection bits. The write stores `{wdata[W-1:1], p}`, where `p` is the XOR of `wdata[W-1:1]`.
- R2: A read request (`en`=1, `we`=0) produces `rvalid`=1 in the following cycle. For a clean word, `rdata` then equals `{wdata[W-1:1], 1'b0}`.
- R3: `rerr` is never high unless `rvalid` is high.
- R4: When the stored word holds an odd number of flipped bits, including a flip of bit 0 alone, the read returns `rdata`=0 with `rerr`=1.
- R5: When the stored word holds an even, nonzero number of flipped bits, the read is not flagged (`rerr`=0). It returns the corrupted upper bits with bit 0 cleared.
- R6: `err_count` (16 bits) increases by one in the cycle after each read that shows `rerr`=1. It holds otherwise and stays at 65535 once reached.
- R7: While `rst` is high on a clock edge, `rvalid`, `rerr` and `err_count` return to 0.
- R8: A write cycle (`en`=1, `we`=1) produces no read response: `rvalid` is 0 in the next cycle.
- R9: An injection (`inj_en`=1) XORs `inj_mask` into the word at `inj_addr` on the clock edge. If a write to the same address happens in the same cycle, the write wins and the injection is dropped. An injection to a different address still applies.
- R10: While `rvalid` is low, `rdata` is 0 and `rerr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Access request |
| we | input | 1 | 1 = write, 0 = read (when en) |
| addr | input | AW | Word address, AW = log2(DEPTH) |
| wdata | input | W | Parameter to store |
| rdata | output | W | Returned parameter (zero when masked) |
| rvalid | output | 1 | Read data valid |
| rerr | output | 1 | Parity mismatch on this read |
| err_count | output | 16 | Saturating count of detected faults |
| inj_en | input | 1 | Test fault-injection enable |
| inj_addr | input | AW | Address to corrupt |
| inj_mask | input | W | Bits to flip |

## Verification
The bound assertions check the following properties on every cycle:
- the one-cycle read strobe timing and the absence of a response to writes;
- that the error flag is qualified by the read strobe;
- that a flagged word reads as zero;
- that bit 0 never reaches the consumer;
- the counter's step, hold and saturation rules.

Only the bench scenarios can show the data-dependent behaviour:
- which flip patterns are detected and which escape;
- the exact value returned after a double flip;
- the write-over-injection priority;
- that the counter actually reaches its ceiling.

// File: rtl/lsbp_pkg.sv
package lsbp_pkg;

    localparam int CNT_W = 16;

    typedef enum logic [1:0] {
        RD_IDLE   = 2'd0,
        RD_CLEAN  = 2'd1,
        RD_MASKED = 2'd2
    } rd_status_e;

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
        return (v == {CNT_W{1'b1}}) ? v : v + {{(CNT_W-1){1'b0}}, 1'b1};
    endfunction

endpackage

// File: rtl/lsbp_encoder.sv
module lsbp_encoder #(
    parameter int W = 16
) (
    input  logic [W-1:0] raw,
    output logic [W-1:0] coded
);
    logic par;

    always_comb begin
        par   = ^raw[W-1:1];
        coded = {raw[W-1:1], par};
    end
endmodule

// File: rtl/lsbp_store.sv
module lsbp_store #(
    parameter int W     = 16,
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic          rd,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wword,
    input  logic          inj_en,
    input  logic [AW-1:0] inj_addr,
    input  logic [W-1:0]  inj_mask,
    output logic [W-1:0]  rword,
    output logic          rvld
);
    logic [W-1:0] mem [DEPTH];
    logic         inj_apply;

    always_comb begin
        inj_apply = inj_en && !(wr && (inj_addr == addr));
    end

    always_ff @(posedge clk) begin
        if (wr) begin
            mem[addr] <= wword;
        end
        if (inj_apply) begin
            mem[inj_addr] <= mem[inj_addr] ^ inj_mask;
        end
        if (rd) begin
            rword <= mem[addr];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rvld <= 1'b0;
        end else begin
            rvld <= rd;
        end
    end
endmodule

// File: rtl/lsbp_check.sv
module lsbp_check
    import lsbp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] word,
    input  logic         vld,
    output logic [W-1:0] data,
    output logic         err,
    output rd_status_e   status
);
    logic mismatch;

    always_comb begin
        mismatch = ^word;
        if (!vld) begin
            status = RD_IDLE;
        end else if (mismatch) begin
            status = RD_MASKED;
        end else begin
            status = RD_CLEAN;
        end

        case (status)
            RD_CLEAN: begin
                data = {word[W-1:1], 1'b0};
                err  = 1'b0;
            end
            RD_MASKED: begin
                data = '0;
                err  = 1'b1;
            end
            default: begin
                data = '0;
                err  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/lsbp_err_counter.sv
module lsbp_err_counter
    import lsbp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  rd_status_e       status,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (status == RD_MASKED) begin
            count <= sat_inc(count);
        end
    end
endmodule

// File: rtl/lsbp_weight_mem.sv
module lsbp_weight_mem
    import lsbp_pkg::*;
#(
    parameter int W     = 16,
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [W-1:0]     wdata,
    output logic [W-1:0]     rdata,
    output logic             rvalid,
    output logic             rerr,
    output logic [CNT_W-1:0] err_count,
    input  logic             inj_en,
    input  logic [AW-1:0]    inj_addr,
    input  logic [W-1:0]     inj_mask
);
    logic [W-1:0] coded;
    logic [W-1:0] rword;
    logic         rvld;
    logic         wr_req;
    logic         rd_req;
    rd_status_e   status;

    always_comb begin
        wr_req = en && we;
        rd_req = en && !we;
    end

    lsbp_encoder #(.W(W)) u_enc (
        .raw   (wdata),
        .coded (coded)
    );

    lsbp_store #(.W(W), .DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr_req),
        .rd       (rd_req),
        .addr     (addr),
        .wword    (coded),
        .inj_en   (inj_en),
        .inj_addr (inj_addr),
        .inj_mask (inj_mask),
        .rword    (rword),
        .rvld     (rvld)
    );

    lsbp_check #(.W(W)) u_chk (
        .word   (rword),
        .vld    (rvld),
        .data   (rdata),
        .err    (rerr),
        .status (status)
    );

    lsbp_err_counter u_cnt (
        .clk    (clk),
        .rst    (rst),
        .status (status),
        .count  (err_count)
    );

    always_comb begin
        rvalid = rvld;
    end
endmodule

// File: rtl/lsbp_weight_mem_sva.sv
module lsbp_weight_mem_sva #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         en,
    input logic         we,
    input logic [W-1:0] rdata,
    input logic         rvalid,
    input logic         rerr,
    input logic [15:0]  err_count
);
    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst) (en && !we) |=> rvalid); // R2
    AST_NO_RESP_WRITE: assert property (@(posedge clk) disable iff (rst) !(en && !we) |=> !rvalid); // R8
    AST_ERR_QUALIFIED: assert property (@(posedge clk) disable iff (rst) rerr |-> rvalid); // R3
    AST_MASK_ZERO: assert property (@(posedge clk) disable iff (rst) rerr |-> (rdata == '0)); // R4
    AST_LSB_HIDDEN: assert property (@(posedge clk) disable iff (rst) rvalid |-> (rdata[0] == 1'b0)); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !rvalid |-> (rdata == '0 && !rerr)); // R10
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst) (rerr && err_count != 16'hFFFF) |=> (err_count == $past(err_count) + 16'd1)); // R6
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst) !rerr |=> $stable(err_count)); // R6
    AST_CNT_SAT: assert property (@(posedge clk) disable iff (rst) (err_count == 16'hFFFF) |=> (err_count == 16'hFFFF)); // R6
    AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (!rvalid && !rerr && err_count == 16'd0)); // R7
endmodule

bind lsbp_weight_mem lsbp_weight_mem_sva #(.W(W)) u_sva (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .we        (we),
    .rdata     (rdata),
    .rvalid    (rvalid),
    .rerr      (rerr),
    .err_count (err_count)
);

// File: tb/lsbp_weight_mem_tb.sv
module lsbp_weight_mem_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 16;
    localparam int DEPTH = 256;
    localparam int AW = 8;
    localparam int NV = 8;

    localparam logic [AW-1:0] V_ADDR [NV] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'hFF, 8'h10, 8'h80};
    localparam logic [W-1:0]  V_DATA [NV] = '{16'h1234, 16'hFFFF, 16'hA5A4, 16'h7FFE,
                                              16'h0F0F, 16'h8001, 16'h0000, 16'hC3C2};
    localparam logic [W-1:0]  V_MASK [NV] = '{16'h0000, 16'h0000, 16'h0001, 16'h8000,
                                              16'h0110, 16'h0040, 16'h0007, 16'h0006};

    logic clk = 1'b0;
    logic rst;
    logic en, we, inj_en;
    logic [AW-1:0] addr, inj_addr;
    logic [W-1:0]  wdata, inj_mask, rdata;
    logic rvalid, rerr;
    logic [15:0] err_count;

    int n_chk = 0;
    int n_err = 0;
    int exp_cnt = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsbp_weight_mem #(.W(W), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .en(en), .we(we), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rvalid(rvalid), .rerr(rerr), .err_count(err_count),
        .inj_en(inj_en), .inj_addr(inj_addr), .inj_mask(inj_mask)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] stored(input logic [W-1:0] w, input logic [W-1:0] m);
        return {w[W-1:1], ^w[W-1:1]} ^ m;
    endfunction

    task automatic idle();
        en = 0; we = 0; inj_en = 0; addr = '0; wdata = '0; inj_addr = '0; inj_mask = '0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d);
        @(negedge clk); idle(); en = 1; we = 1; addr = a; wdata = d;
        @(negedge clk); idle();
    endtask

    task automatic inj(input logic [AW-1:0] a, input logic [W-1:0] m);
        @(negedge clk); idle(); inj_en = 1; inj_addr = a; inj_mask = m;
        @(negedge clk); idle();
    endtask

    task automatic rd_check(input logic [AW-1:0] a, input logic [W-1:0] w,
                            input logic [W-1:0] m, input string req);
        logic [W-1:0] s;
        logic [W-1:0] ed;
        logic ee;
        s  = stored(w, m);
        ee = ^s;
        ed = ee ? '0 : {s[W-1:1], 1'b0};
        @(negedge clk); idle(); en = 1; we = 0; addr = a;
        @(negedge clk); idle();
        chk(rvalid == 1'b1, req, {31'd0, rvalid}, 32'd1);
        chk(rdata == ed, req, {16'd0, rdata}, {16'd0, ed});
        chk(rerr == ee, req, {31'd0, rerr}, {31'd0, ee});
        if (ee) exp_cnt++;
        @(negedge clk);
        chk(err_count == exp_cnt[15:0], {req, " R6 count"}, {16'd0, err_count}, exp_cnt);
        chk(rvalid == 1'b0 && rdata == '0 && rerr == 1'b0, "R10 idle", {15'd0, rvalid, rdata}, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        idle();
        rst = 1;
        repeat (3) @(negedge clk);
        // R7: reset state
        chk(rvalid == 0 && rerr == 0 && err_count == 0, "R7 reset", {15'd0, rvalid, err_count}, 32'd0);
        rst = 0;

        // Vector table: R1, R2, R4, R5 via write / inject / read
        for (int i = 0; i < NV; i++) begin
            wr(V_ADDR[i], V_DATA[i]);
            if (V_MASK[i] != '0) inj(V_ADDR[i], V_MASK[i]);
            rd_check(V_ADDR[i], V_DATA[i], V_MASK[i],
                     (V_MASK[i] == '0) ? "R1/R2 clean" :
                     (^V_MASK[i]) ? "R4 odd flip" : "R5 even flip");
        end

        // R8: a write produces no read response
        @(negedge clk); idle(); en = 1; we = 1; addr = 8'h30; wdata = 16'h5555;
        @(negedge clk); idle();
        chk(rvalid == 0, "R8 write no resp", {31'd0, rvalid}, 32'd0);
        rd_check(8'h30, 16'h5555, 16'h0000, "R8 readback");

        // R9: same-address write beats injection
        @(negedge clk); idle(); en = 1; we = 1; addr = 8'h20; wdata = 16'h3C3C;
        inj_en = 1; inj_addr = 8'h20; inj_mask = 16'h0100;
        @(negedge clk); idle();
        rd_check(8'h20, 16'h3C3C, 16'h0000, "R9 write wins");

        // R9: different-address injection still applies
        wr(8'h22, 16'h1111);
        @(negedge clk); idle(); en = 1; we = 1; addr = 8'h21; wdata = 16'h2222;
        inj_en = 1; inj_addr = 8'h22; inj_mask = 16'h0800;
        @(negedge clk); idle();
        rd_check(8'h21, 16'h2222, 16'h0000, "R9 other write");
        rd_check(8'h22, 16'h1111, 16'h0800, "R9 other inject");

        // R6: saturation with back-to-back faulty reads
        @(negedge clk); idle(); en = 1; we = 0; addr = 8'h22;
        repeat (65600) @(negedge clk);
        idle();
        repeat (3) @(negedge clk);
        chk(err_count == 16'hFFFF, "R6 saturate", {16'd0, err_count}, 32'h0000FFFF);

        // R7: reset clears counter
        rst = 1;
        @(negedge clk);
        rst = 0;
        chk(err_count == 0 && rvalid == 0, "R7 clear", {15'd0, rvalid, err_count}, 32'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule